// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a shared, single-wire interrupt line that many peripherals pull low through open-drain outputs. The host repeats a fixed cycle. A Start frame holds the wire low. A run of data slots follows, each three clocks long, and a peripheral marks its interrupt by pulling the wire low in the first clock of its slot. A Stop frame closes the cycle, and its length tells every device on the wire whether the next cycle runs in continuous or quiet mode.

In continuous mode the host opens every cycle by itself. In quiet mode the host stays off the wire until a peripheral pulls it low for one clock, and then the host extends that pulse into a full Start frame. The level seen in each live slot is gathered in a shadow register. When the Stop frame begins, the whole shadow is copied into a parallel interrupt vector.

Top module: `serirq_host`

## Requirements
- R1: While `rst_n` is low, both wire drivers are off and `irq_status` is zero. Reset selects continuous mode, and the host pulls the wire low in the first clock after reset is released.
- R2: In continuous mode the Start frame pulls the wire low for 4 + min(`cfg_start_ext`, 4) consecutive clocks. `cfg_start_ext` is 3 bits wide, so any value from 4 to 7 gives 8 clocks.
- R3: In quiet mode the host never drives the wire while idle. Once it samples the wire low at a clock edge, it pulls the wire low for 3 + min(`cfg_start_ext`, 4) clocks, starting in the next clock.
- R4: Every Start frame low period is followed by exactly one clock of `wire_push_high`, then one clock with both drivers off, then the sample clock of slot 0.
- R5: Each data slot lasts three clocks: sample, recovery, turnaround. The host drives nothing during slots and reads the wire only in the sample clock, where low means asserted. A low in the recovery clock has no effect on `irq_status`.
- R6: Bit n of `irq_status` carries slot n. Bit 2 (the system-management slot) and any bit at 16 or above always read 0.
- R7: `irq_status` changes only at the edge that starts the Stop frame's low period, where all bits update together. It holds its value for the rest of the cycle.
- R8: The Stop frame pulls the wire low for 2 clocks when `cfg_quiet` is 1, or for 3 clocks when it is 0, taking the value sampled at the end of the last slot. One push-high clock and one released clock follow.
- R9: After a 3-clock Stop the next Start frame begins in the clock straight after the released clock. After a 2-clock Stop the host waits in quiet mode.
- R10: `wire_pull_low` and `wire_push_high` are never asserted in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared wire (high when nothing pulls it) |
| cfg_quiet | input | 1 | 1: end cycle with a 2-clock Stop (quiet next); 0: 3-clock Stop (continuous next) |
| cfg_start_ext | input | 3 | Extra Start-frame low clocks beyond the minimum, capped at 4 |
| wire_pull_low | output | 1 | Open-drain enable that pulls the wire low |
| wire_push_high | output | 1 | One-clock active high drive after a low period |
| irq_status | output | NUM_FRAMES | Interrupt levels captured in the last completed cycle |

## Verification
The bench aims at the Start-length clamp. A design that did not cap the extension would hold the wire low for 11 clocks when the field is 7. It also covers the one-clock difference between a host-started and a peripheral-started Start frame, where an off-by-one would stretch the total quiet-mode low to 5 to 9 clocks. Lows placed in recovery clocks and in slot 2 would show up as spurious interrupt bits if sampling were misplaced or masking missing. A status vector that changed while slots were still being sampled, or a Stop length that ignored the mode setting, would show up as a wrong value in the first Stop clock, or as a Start frame appearing or missing after the released clock.

// File: rtl/serirq_pkg.sv
// Shared constants, state types and helper functions for the serial
// interrupt host. Assumes one clock domain for all users.
package serirq_pkg;

    localparam int EXT_W          = 3;   // width of the Start extension field
    localparam int CNT_W          = 4;   // width of the low-period down counter
    localparam int START_BASE     = 4;   // minimum Start low clocks
    localparam int EXT_CAP        = 4;   // largest honoured extension
    localparam int STOP_LOW_QUIET = 2;   // Stop low clocks that select quiet
    localparam int STOP_LOW_CONT  = 3;   // Stop low clocks that select continuous
    localparam int LIVE_SLOTS     = 16;  // slots at or above this are unassigned
    localparam int SMI_SLOT       = 2;   // unsupported system-management slot

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LOW,
        ST_START_HIGH,
        ST_START_TURN,
        ST_DATA,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } slot_phase_t;

    // Reload value (clocks minus one) of the host's share of a Start frame.
    function automatic logic [CNT_W-1:0] start_reload(input logic [EXT_W-1:0] ext,
                                                      input logic periph_began);
        logic [CNT_W-1:0] extra;
        logic [CNT_W-1:0] total;
        extra = (ext > EXT_W'(EXT_CAP)) ? CNT_W'(EXT_CAP) : CNT_W'(ext);
        total = CNT_W'(START_BASE) + extra - (periph_began ? CNT_W'(1) : CNT_W'(0));
        return total - CNT_W'(1);
    endfunction

    // True for slots whose level is reported in the status vector.
    function automatic bit slot_live(input int k);
        return (k != SMI_SLOT) && (k < LIVE_SLOTS);
    endfunction

endpackage

// File: rtl/serirq_seq.sv
// Frame sequencer: walks Start, data slots and Stop, and drives the wire.
// Assumes line_in is already synchronous to clk. Outputs decode the state
// register directly, so they change one clock after each decision.
module serirq_seq
    import serirq_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             cfg_quiet,
    input  logic [EXT_W-1:0] cfg_start_ext,
    output logic             pull_low,
    output logic             push_high,
    output logic             sample_en,
    output logic [IDX_W-1:0] sample_idx,
    output logic             stop_begin
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0] STOP_Q_RELOAD = CNT_W'(STOP_LOW_QUIET - 1);
    localparam logic [CNT_W-1:0] STOP_C_RELOAD = CNT_W'(STOP_LOW_CONT - 1);

    seq_state_t       state_q, state_d;
    slot_phase_t      phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] frame_q, frame_d;
    logic             mode_quiet_q, mode_quiet_d;
    logic             stop_quiet_q, stop_quiet_d;
    logic             last_turn;

    assign last_turn = (state_q == ST_DATA) && (phase_q == PH_TURN) && (frame_q == LAST_IDX);

    // Next-state and counter decisions for the whole frame sequence.
    always_comb begin
        state_d      = state_q;
        phase_d      = phase_q;
        cnt_d        = cnt_q;
        frame_d      = frame_q;
        mode_quiet_d = mode_quiet_q;
        stop_quiet_d = stop_quiet_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_quiet_q) begin
                    state_d = ST_START_LOW;
                    cnt_d   = start_reload(cfg_start_ext, 1'b0);
                end else if (!line_in) begin
                    state_d = ST_START_LOW;
                    cnt_d   = start_reload(cfg_start_ext, 1'b1);
                end
            end
            ST_START_LOW: begin
                if (cnt_q == '0) state_d = ST_START_HIGH;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_START_HIGH: state_d = ST_START_TURN;
            ST_START_TURN: begin
                state_d = ST_DATA;
                frame_d = '0;
                phase_d = PH_SAMPLE;
            end
            ST_DATA: begin
                unique case (phase_q)
                    PH_SAMPLE:  phase_d = PH_RECOVER;
                    PH_RECOVER: phase_d = PH_TURN;
                    default: begin
                        phase_d = PH_SAMPLE;
                        if (last_turn) begin
                            state_d      = ST_STOP_LOW;
                            stop_quiet_d = cfg_quiet;
                            cnt_d        = cfg_quiet ? STOP_Q_RELOAD : STOP_C_RELOAD;
                        end else begin
                            frame_d = frame_q + 1'b1;
                        end
                    end
                endcase
            end
            ST_STOP_LOW: begin
                if (cnt_q == '0) state_d = ST_STOP_HIGH;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_STOP_HIGH: state_d = ST_GAP;
            ST_GAP: begin
                mode_quiet_d = stop_quiet_q;
                if (stop_quiet_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_START_LOW;
                    cnt_d   = start_reload(cfg_start_ext, 1'b0);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers; reset lands in idle with continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            phase_q      <= PH_SAMPLE;
            cnt_q        <= '0;
            frame_q      <= '0;
            mode_quiet_q <= 1'b0;
            stop_quiet_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            phase_q      <= phase_d;
            cnt_q        <= cnt_d;
            frame_q      <= frame_d;
            mode_quiet_q <= mode_quiet_d;
            stop_quiet_q <= stop_quiet_d;
        end
    end

    // Wire drive and capture strobes decoded from the registered state.
    always_comb begin
        pull_low   = (state_q == ST_START_LOW) || (state_q == ST_STOP_LOW);
        push_high  = (state_q == ST_START_HIGH) || (state_q == ST_STOP_HIGH);
        sample_en  = (state_q == ST_DATA) && (phase_q == PH_SAMPLE);
        sample_idx = frame_q;
        stop_begin = last_turn;
    end

endmodule

// File: rtl/serirq_capture.sv
// Slot capture: stores the sampled level of each live slot in a shadow
// register and copies every shadow bit into the status vector together
// when the Stop frame starts. Dead slots are tied to zero.
module serirq_capture
    import serirq_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    input  logic                  sample_en,
    input  logic [IDX_W-1:0]      sample_idx,
    input  logic                  stop_begin,
    output logic [NUM_FRAMES-1:0] irq_status
);

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_slot
        if (slot_live(k)) begin : g_live
            logic shadow_q;
            logic status_q;

            // Capture the active-low level in this slot's sample clock.
            always_ff @(posedge clk) begin
                if (!rst_n)                                        shadow_q <= 1'b0;
                else if (sample_en && (sample_idx == IDX_W'(k)))   shadow_q <= ~line_in;
            end

            // Publish the shadow bit when the Stop frame begins.
            always_ff @(posedge clk) begin
                if (!rst_n)          status_q <= 1'b0;
                else if (stop_begin) status_q <= shadow_q;
            end

            assign irq_status[k] = status_q;
        end else begin : g_dead
            assign irq_status[k] = 1'b0;
        end
    end

endmodule

// File: rtl/serirq_host.sv
// Host side of a shared open-drain serial interrupt wire. Joins the frame
// sequencer and the slot capture. Assumes line_in is sampled in the clk
// domain and that the wire floats high when nothing pulls it.
module serirq_host
    import serirq_pkg::*;
#(
    parameter int NUM_FRAMES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    input  logic                  cfg_quiet,
    input  logic [EXT_W-1:0]      cfg_start_ext,
    output logic                  wire_pull_low,
    output logic                  wire_push_high,
    output logic [NUM_FRAMES-1:0] irq_status
);

    localparam int IDX_W = $clog2(NUM_FRAMES);

    logic             sample_en;
    logic [IDX_W-1:0] sample_idx;
    logic             stop_begin;

    serirq_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .cfg_quiet     (cfg_quiet),
        .cfg_start_ext (cfg_start_ext),
        .pull_low      (wire_pull_low),
        .push_high     (wire_push_high),
        .sample_en     (sample_en),
        .sample_idx    (sample_idx),
        .stop_begin    (stop_begin)
    );

    serirq_capture #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .sample_en  (sample_en),
        .sample_idx (sample_idx),
        .stop_begin (stop_begin),
        .irq_status (irq_status)
    );

endmodule

// File: rtl/serirq_host_chk.sv
// Protocol checker bound to serirq_host. Watches only the top-level ports
// and keeps its own run-length counter for the low period.
module serirq_host_chk #(
    parameter int NUM_FRAMES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wire_pull_low,
    input logic                  wire_push_high,
    input logic [NUM_FRAMES-1:0] irq_status
);

    logic [3:0] low_run_q;

    // Count consecutive host low clocks, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run_q <= '0;
        else if (!wire_pull_low) low_run_q <= '0;
        else if (low_run_q != 4'hF) low_run_q <= low_run_q + 1'b1;
    end

    assert_exclusive_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wire_pull_low && wire_push_high));

    assert_low_ends_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wire_pull_low) |-> wire_push_high);

    assert_high_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wire_push_high |=> (!wire_push_high && !wire_pull_low));

    assert_status_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_status) |-> $rose(wire_pull_low));

    assert_low_run_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= 4'd8);

    if (NUM_FRAMES > 2) begin : g_slot2
        assert_smi_slot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_status[2] == 1'b0);
    end

endmodule

bind serirq_host serirq_host_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wire_pull_low  (wire_pull_low),
    .wire_push_high (wire_push_high),
    .irq_status     (irq_status)
);

// File: tb/serirq_host_tb.sv
`timescale 1ns/1ps
module serirq_host_tb;

    localparam int NF = 16;
    localparam logic [NF-1:0] LIVE_MASK = 16'hFFFB;
    localparam int NROWS = 6;
    // Row fields: {ext[35:33], next_quiet[32], slot lows[31:16], recovery lows[15:0]}
    localparam logic [35:0] VEC [NROWS] = '{
        {3'd0, 1'b0, 16'h0001, 16'h0000},
        {3'd7, 1'b0, 16'h8004, 16'h0002},
        {3'd2, 1'b1, 16'hFFFF, 16'h0000},
        {3'd1, 1'b1, 16'h5A5A, 16'h00FF},
        {3'd4, 1'b0, 16'h0000, 16'hFFFF},
        {3'd5, 1'b1, 16'h1230, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          periph_low = 1'b0;
    logic          cfg_quiet = 1'b0;
    logic [2:0]    cfg_start_ext = 3'd0;
    logic          wire_pull_low;
    logic          wire_push_high;
    logic [NF-1:0] irq_status;
    logic          line;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [NF-1:0] prev_status = '0;

    always #2.5 clk = ~clk;

    assign line = (wire_pull_low || periph_low) ? 1'b0 : 1'b1;

    serirq_host #(.NUM_FRAMES(NF)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_in        (line),
        .cfg_quiet      (cfg_quiet),
        .cfg_start_ext  (cfg_start_ext),
        .wire_pull_low  (wire_pull_low),
        .wire_push_high (wire_push_high),
        .irq_status     (irq_status)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drv(input string req, input string what, input logic lo, input logic hi);
        chk(req, {what, " pull_low"}, wire_pull_low, lo);
        chk(req, {what, " push_high"}, wire_push_high, hi);
    endtask

    function automatic int capped(input logic [2:0] e);
        return (e > 3'd4) ? 4 : int'(e);
    endfunction

    // One full cycle, entered at a negedge just before the first Start clock
    // (continuous) or the first idle clock (quiet).
    task automatic do_cycle(input logic quiet_now, input logic [2:0] ext,
                            input logic [NF-1:0] pat, input logic [NF-1:0] noise,
                            input logic nq, input logic [2:0] ext_next);
        int host_low;
        int stop_len;
        logic [NF-1:0] exp;
        cfg_quiet = nq;
        if (quiet_now) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                drv("R3 R9", "quiet idle", 1'b0, 1'b0);
            end
            @(negedge clk);
            periph_low = 1'b1;
            drv("R3", "peripheral start clock", 1'b0, 1'b0);
            @(negedge clk);
            periph_low = 1'b0;
            host_low = 3 + capped(ext);
        end else begin
            host_low = 4 + capped(ext);
        end
        for (int i = 0; i < host_low; i++) begin
            if (!(quiet_now && i == 0)) @(negedge clk);
            drv(quiet_now ? "R3" : "R2 R9", "start low", 1'b1, 1'b0);
        end
        @(negedge clk);
        drv("R4", "start push high", 1'b0, 1'b1);
        @(negedge clk);
        drv("R4", "start release", 1'b0, 1'b0);
        for (int k = 0; k < NF; k++) begin
            @(negedge clk);
            periph_low = pat[k];
            drv("R5", "sample clock", 1'b0, 1'b0);
            if (k == 0) chk("R7", "status held into slots", irq_status, prev_status);
            @(negedge clk);
            periph_low = noise[k];
            drv("R5", "recovery clock", 1'b0, 1'b0);
            @(negedge clk);
            periph_low = 1'b0;
            drv("R5", "turnaround clock", 1'b0, 1'b0);
        end
        stop_len = nq ? 2 : 3;
        exp = pat & LIVE_MASK;
        for (int i = 0; i < stop_len; i++) begin
            @(negedge clk);
            drv("R8", "stop low", 1'b1, 1'b0);
            if (i == 0) begin
                chk("R5 R6 R7", "status at stop", irq_status, exp);
                cfg_start_ext = ext_next;
            end
        end
        @(negedge clk);
        drv("R8", "stop push high", 1'b0, 1'b1);
        @(negedge clk);
        drv("R8", "stop release", 1'b0, 1'b0);
        prev_status = exp;
    endtask

    initial begin
        logic quiet_now;
        logic [2:0] nx;
        cfg_start_ext = VEC[0][35:33];
        repeat (3) @(negedge clk);
        drv("R1", "in reset", 1'b0, 1'b0);
        chk("R1", "status in reset", irq_status, 0);
        rst_n = 1'b1;
        quiet_now = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            nx = (i + 1 < NROWS) ? VEC[i + 1][35:33] : 3'd3;
            do_cycle(quiet_now, VEC[i][35:33], VEC[i][31:16], VEC[i][15:0],
                     VEC[i][32], nx);
            quiet_now = VEC[i][32];
        end
        // Quiet mode with no peripheral request: host stays off the wire.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            drv("R3", "long quiet idle", 1'b0, 1'b0);
        end
        // Reset from quiet idle returns to continuous and clears status.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        drv("R1", "reset from quiet", 1'b0, 1'b0);
        chk("R1", "status cleared", irq_status, 0);
        cfg_start_ext = 3'd3;
        rst_n = 1'b1;
        prev_status = '0;
        do_cycle(1'b0, 3'd3, 16'h0810, 16'h0000, 1'b0, 3'd3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule